// File: doc/BRIEF.md
# CRT Controller Host Register File

This block is the processor-facing side of a CRT controller. It decodes a 16-bit I/O address into four access functions, keeps a 5-bit index register and eighteen control registers, and answers reads under a fixed policy. Most registers can only be written. The cursor pair can be read and written. The light-pen pair can only be read. A sparse status byte reports light-pen and vertical-border events.

The timing engine beside it takes its configuration from the `regs_o` bus. It feeds back three things: the current 14-bit video memory address, a level that is high while the vertical character count sits in the border region, and a one-cycle pulse at the start of each frame. The host latches the video address into the light-pen pair with a strobe.

Top module: `crtc_regfile`

## Requirements
- R1: An access takes effect only when io_addr[14] is 0. When io_addr[14] is 1, writes change neither the index nor any register, and io_rdata is 0. Address bits other than 14, 9 and 8 have no effect.
- R2: io_addr[9:8] selects the function: 00 writes the index from io_wdata[4:0], 01 writes the selected register, 10 reads status, and 11 reads the selected register. Writes use io_wr and reads use io_rd. An access whose strobe does not match its function does nothing, and io_rdata is then 0.
- R3: A register write keeps only the implemented bits and stores 0 in the rest. Registers 12, 14 and 16 keep bits 5:0. Registers 4, 6 and 7 keep bits 6:0. Registers 5, 9, 10 and 11 keep bits 4:0. Registers 0–3, 8, 13, 15 and 17 keep all 8 bits.
- R4: Data reads of indexes 0 through 13 return 0, whatever those registers hold.
- R5: Indexes 14 and 15 (cursor address) read back the value written, after the R3 masking.
- R6: On lpen_stb, register 16 takes {2'b00, cur_ma[13:8]} and register 17 takes cur_ma[7:0] at the next clock. Data writes to 16 and 17 are ignored. Data reads of 16 and 17 return their contents.
- R7: Data reads of indexes 18–30 return 0 and index 31 returns 8'hFF. Data writes to indexes 18–31 change nothing.
- R8: Status bit 6 is set by lpen_stb. It is cleared by a data read of index 16 or 17. A strobe in the same cycle as such a read leaves the bit set.
- R9: Status bit 5 is set in any cycle in which vert_border is high. It is cleared by frame_start, which wins when both are high. Status bits 7 and 4:0 read 0.
- R10: After reset, the index, all eighteen registers and both status flags are 0.
- R11: io_rdata is combinational from the current state and the inputs. It is 0 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address: bit 14 is the select, bits 9:8 the function |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| lpen_stb | input | 1 | Light-pen strobe |
| cur_ma | input | 14 | Current video memory address |
| vert_border | input | 1 | High while the vertical border region is active |
| frame_start | input | 1 | One-cycle pulse at frame start |
| io_rdata | output | 8 | Read data |
| regs_o | output | 18x8 | Control register contents, index 0 in the low byte |

## Verification
The hardest cases to reach from the ports are collisions between event sources and host reads. Examples are a light-pen strobe in the same cycle as a read of register 16 or 17, and a frame-start pulse together with vert_border. The stimulus forces these collisions in directed cycles. It then runs a long random phase in which all strobes, functions, indexes and side inputs vary together, with address junk in the don't-care bits. A behavioural model checks every cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 5;
    localparam int MA_W     = 14;
    localparam int NUM_REGS = 18;

    localparam int CUR_HI_N  = 14;
    localparam int CUR_LO_N  = 15;
    localparam int LPEN_HI_N = 16;
    localparam int LPEN_LO_N = 17;

    localparam logic [IDX_W-1:0] IX_CUR_HI  = IDX_W'(CUR_HI_N);
    localparam logic [IDX_W-1:0] IX_CUR_LO  = IDX_W'(CUR_LO_N);
    localparam logic [IDX_W-1:0] IX_LPEN_HI = IDX_W'(LPEN_HI_N);
    localparam logic [IDX_W-1:0] IX_LPEN_LO = IDX_W'(LPEN_LO_N);
    localparam logic [IDX_W-1:0] IX_DUMMY   = {IDX_W{1'b1}};

    localparam int STAT_LPEN_BIT = 6;
    localparam int STAT_VB_BIT   = 5;

    typedef enum logic [1:0] {
        FN_INDEX  = 2'b00,
        FN_WRITE  = 2'b01,
        FN_STATUS = 2'b10,
        FN_READ   = 2'b11
    } crtc_fn_e;

    // implemented-bit mask of each control register
    function automatic logic [DATA_W-1:0] reg_mask(input int unsigned i);
        case (i)
            4, 6, 7:        reg_mask = 8'h7F;
            5, 9, 10, 11:   reg_mask = 8'h1F;
            12, 14, 16:     reg_mask = 8'h3F;
            default:        reg_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/crtc_io_decode.sv
module crtc_io_decode #(
    parameter int ADDR_W  = 16,
    parameter int SEL_BIT = 14,
    parameter int FN_LSB  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              idx_we,
    output logic              data_we,
    output logic              stat_re,
    output logic              data_re
);
    import crtc_pkg::*;

    logic     chip_sel;
    crtc_fn_e fn;
    logic     unused_addr;

    assign chip_sel    = ~addr[SEL_BIT];
    assign fn          = crtc_fn_e'(addr[FN_LSB+1:FN_LSB]);
    assign unused_addr = ^addr;

    always_comb begin
        idx_we  = 1'b0;
        data_we = 1'b0;
        stat_re = 1'b0;
        data_re = 1'b0;
        if (chip_sel) begin
            case (fn)
                FN_INDEX:  idx_we  = wr;
                FN_WRITE:  data_we = wr;
                FN_STATUS: stat_re = rd;
                FN_READ:   data_re = rd;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
    import crtc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              data_we,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              lpen_stb,
    input  logic [MA_W-1:0]                   cur_ma,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    localparam int HI_W  = MA_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] r;
    } bank_t;

    bank_t                            bank_d, bank_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]  mask;
    logic [NUM_REGS-1:0]              writable;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg_attr
        assign mask[g]     = reg_mask(g);
        assign writable[g] = (g < LPEN_HI_N);
    end

    always_comb begin
        bank_d = bank_q;
        if (data_we) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (idx == IDX_W'(i) && writable[i])
                    bank_d.r[i] = wdata & mask[i];
            end
        end
        if (lpen_stb) begin
            bank_d.r[LPEN_HI_N] = {{PAD_W{1'b0}}, cur_ma[MA_W-1:DATA_W]};
            bank_d.r[LPEN_LO_N] = cur_ma[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign regs = bank_q.r;
endmodule

// File: rtl/crtc_status_unit.sv
module crtc_status_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic lpen_stb,
    input  logic lpen_clr,
    input  logic vert_border,
    input  logic frame_start,
    output logic lpen_flag,
    output logic vb_flag
);
    typedef struct packed {
        logic lpen;
        logic vb;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d      = stat_q;
        // a fresh strobe outranks the clearing read
        stat_d.lpen = (stat_q.lpen & ~lpen_clr) | lpen_stb;
        // frame start outranks the border level
        stat_d.vb   = (stat_q.vb | vert_border) & ~frame_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign lpen_flag = stat_q.lpen;
    assign vb_flag   = stat_q.vb;
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SEL_BIT = 14,
    parameter int FN_LSB  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                io_addr,
    input  logic [DATA_W-1:0]                io_wdata,
    input  logic                             io_rd,
    input  logic                             io_wr,
    input  logic                             lpen_stb,
    input  logic [MA_W-1:0]                  cur_ma,
    input  logic                             vert_border,
    input  logic                             frame_start,
    output logic [DATA_W-1:0]                io_rdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } sel_t;

    sel_t sel_d, sel_q;
    logic idx_we, data_we, stat_re, data_re;
    logic lpen_clr, lpen_flag, vb_flag;

    crtc_io_decode #(
        .ADDR_W (ADDR_W),
        .SEL_BIT(SEL_BIT),
        .FN_LSB (FN_LSB)
    ) u_dec (
        .addr   (io_addr),
        .rd     (io_rd),
        .wr     (io_wr),
        .idx_we (idx_we),
        .data_we(data_we),
        .stat_re(stat_re),
        .data_re(data_re)
    );

    always_comb begin
        sel_d = sel_q;
        if (idx_we) sel_d.idx = io_wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    crtc_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (sel_q.idx),
        .data_we (data_we),
        .wdata   (io_wdata),
        .lpen_stb(lpen_stb),
        .cur_ma  (cur_ma),
        .regs    (regs_o)
    );

    assign lpen_clr = data_re &&
                      (sel_q.idx == IX_LPEN_HI || sel_q.idx == IX_LPEN_LO);

    crtc_status_unit u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .lpen_stb   (lpen_stb),
        .lpen_clr   (lpen_clr),
        .vert_border(vert_border),
        .frame_start(frame_start),
        .lpen_flag  (lpen_flag),
        .vb_flag    (vb_flag)
    );

    always_comb begin
        io_rdata = '0;
        if (stat_re) begin
            io_rdata[STAT_LPEN_BIT] = lpen_flag;
            io_rdata[STAT_VB_BIT]   = vb_flag;
        end else if (data_re) begin
            case (sel_q.idx)
                IX_CUR_HI:  io_rdata = regs_o[CUR_HI_N];
                IX_CUR_LO:  io_rdata = regs_o[CUR_LO_N];
                IX_LPEN_HI: io_rdata = regs_o[LPEN_HI_N];
                IX_LPEN_LO: io_rdata = regs_o[LPEN_LO_N];
                IX_DUMMY:   io_rdata = '1;
                default:    io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk
    import crtc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SEL_BIT = 14,
    parameter int FN_LSB  = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ADDR_W-1:0]                io_addr,
    input logic                             io_rd,
    input logic                             io_wr,
    input logic                             lpen_stb,
    input logic [MA_W-1:0]                  cur_ma,
    input logic [DATA_W-1:0]                io_rdata,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    localparam int PAD_W = 2 * DATA_W - MA_W;

    logic stat_rd;
    assign stat_rd = io_rd && !io_addr[SEL_BIT] &&
                     (io_addr[FN_LSB+1:FN_LSB] == FN_STATUS);

    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[SEL_BIT] && !lpen_stb) |=> $stable(regs_o)); // R1

    AST_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o[12][7:6] == 2'b00) && (regs_o[CUR_HI_N][7:6] == 2'b00) &&
        (regs_o[4][7] == 1'b0) && (regs_o[9][7:5] == 3'b000)); // R3

    AST_LPEN_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        lpen_stb |=> regs_o[LPEN_HI_N] ==
                     {{PAD_W{1'b0}}, $past(cur_ma[MA_W-1:DATA_W])}); // R6

    AST_LPEN_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        lpen_stb |=> regs_o[LPEN_LO_N] == $past(cur_ma[DATA_W-1:0])); // R6

    AST_LPEN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !lpen_stb |=> ($stable(regs_o[LPEN_HI_N]) && $stable(regs_o[LPEN_LO_N]))); // R6

    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (io_rdata[7] == 1'b0 && io_rdata[4:0] == 5'b0)); // R9

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0); // R11
endmodule

bind crtc_regfile crtc_regfile_chk #(
    .ADDR_W (ADDR_W),
    .SEL_BIT(SEL_BIT),
    .FN_LSB (FN_LSB)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .lpen_stb(lpen_stb),
    .cur_ma  (cur_ma),
    .io_rdata(io_rdata),
    .regs_o  (regs_o)
);

// File: tb/crtc_regfile_test.sv
`timescale 1ns/100ps
module crtc_regfile_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      io_addr = '0;
    logic [7:0]       io_wdata = '0;
    logic             io_rd = 1'b0;
    logic             io_wr = 1'b0;
    logic             lpen_stb = 1'b0;
    logic [13:0]      cur_ma = '0;
    logic             vert_border = 1'b0;
    logic             frame_start = 1'b0;
    logic [7:0]       io_rdata;
    logic [17:0][7:0] regs_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int m_reg[18];
    int m_idx;
    bit m_lpen, m_vb;

    always #2.5 clk = ~clk;

    crtc_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .lpen_stb(lpen_stb), .cur_ma(cur_ma),
        .vert_border(vert_border), .frame_start(frame_start),
        .io_rdata(io_rdata), .regs_o(regs_o)
    );

    function automatic int keep_bits(int i);
        case (i)
            12, 14, 16:   return 'h3F;
            4, 6, 7:      return 'h7F;
            5, 9, 10, 11: return 'h1F;
            default:      return 'hFF;
        endcase
    endfunction

    function automatic int expect_rdata(logic [15:0] a, bit rd);
        if (!rd || a[14]) return 0;
        case (a[9:8])
            2'b10: return (int'(m_lpen) << 6) | (int'(m_vb) << 5);
            2'b11: begin
                if (m_idx >= 14 && m_idx <= 17) return m_reg[m_idx];
                if (m_idx == 31) return 'hFF;
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] mk_addr(int fn);
        return (16'($urandom) & 16'hBCFF) | 16'(fn << 8);
    endfunction

    task automatic check(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all(string req);
        check(req, "io_rdata", int'(io_rdata), expect_rdata(io_addr, io_rd));
        for (int i = 0; i < 18; i++)
            check(req, $sformatf("regs_o[%0d]", i), int'(regs_o[i]), m_reg[i]);
    endtask

    task automatic model_step(logic [15:0] a, int d, bit rd, bit wr,
                              bit lp, int ma, bit vb, bit fs);
        int old_idx;
        bit sel;
        old_idx = m_idx;
        sel = !a[14];
        if (wr && sel && a[9:8] == 2'b00) m_idx = d & 31;
        if (wr && sel && a[9:8] == 2'b01 && old_idx < 16)
            m_reg[old_idx] = d & keep_bits(old_idx);
        if (rd && sel && a[9:8] == 2'b11 && (old_idx == 16 || old_idx == 17))
            m_lpen = 1'b0;
        if (lp) begin
            m_lpen = 1'b1;
            m_reg[16] = (ma >> 8) & 'h3F;
            m_reg[17] = ma & 'hFF;
        end
        if (vb) m_vb = 1'b1;
        if (fs) m_vb = 1'b0;
    endtask

    // inputs change just after a falling edge; compare before the rising edge
    task automatic cyc(string req, logic [15:0] a, int d, bit rd, bit wr,
                       bit lp = 0, int ma = 0, bit vb = 0, bit fs = 0);
        io_addr = a; io_wdata = 8'(d); io_rd = rd; io_wr = wr;
        lpen_stb = lp; cur_ma = 14'(ma); vert_border = vb; frame_start = fs;
        #1;
        compare_all(req);
        @(posedge clk);
        model_step(a, d, rd, wr, lp, ma, vb, fs);
        @(negedge clk);
    endtask

    task automatic sel_idx(string req, int i);
        cyc(req, mk_addr(0), i, 0, 1);
    endtask
    task automatic wr_reg(string req, int v);
        cyc(req, mk_addr(1), v, 0, 1);
    endtask
    task automatic rd_stat(string req);
        cyc(req, mk_addr(2), 0, 1, 0);
    endtask
    task automatic rd_reg(string req);
        cyc(req, mk_addr(3), 0, 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 18; i++) m_reg[i] = 0;
        m_idx = 0; m_lpen = 0; m_vb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, status and register contents
        rd_stat("R10");
        cyc("R10", mk_addr(3), 0, 1, 0);

        // R3 R4 R5: fill every register with ones, then read back
        for (int i = 0; i < 18; i++) begin
            sel_idx("R2", i);
            wr_reg("R3", 'hFF);
            rd_reg(i < 14 ? "R4" : (i < 16 ? "R5" : "R6"));
        end
        sel_idx("R5", 14); wr_reg("R5", 'hA5); rd_reg("R5");
        sel_idx("R5", 15); wr_reg("R5", 'h5A); rd_reg("R5");

        // R2: index taken from low five bits only
        cyc("R2", mk_addr(0), 'hEF, 0, 1);
        rd_reg("R2");
        // R2: mismatched strobe and function do nothing
        cyc("R2", mk_addr(1), 'h11, 1, 0);
        cyc("R2", mk_addr(3), 'h22, 0, 1);
        rd_reg("R2");

        // R1: deselected accesses
        cyc("R1", mk_addr(0) | 16'h4000, 5, 0, 1);
        cyc("R1", mk_addr(1) | 16'h4000, 'h33, 0, 1);
        cyc("R1", mk_addr(3) | 16'h4000, 0, 1, 0);
        rd_reg("R1");

        // R6 R8: light pen capture, read-only, flag
        cyc("R6", mk_addr(2), 0, 1, 0, 1, 'h2ABC);
        rd_stat("R8");
        sel_idx("R6", 16); wr_reg("R6", 'h77);
        rd_stat("R8");
        rd_reg("R8");
        rd_stat("R8");
        cyc("R8", mk_addr(2), 0, 0, 0, 1, 'h1234);
        sel_idx("R8", 17);
        cyc("R8", mk_addr(3), 0, 1, 0, 1, 'h3FFF);
        rd_stat("R8");
        rd_reg("R8");
        rd_stat("R8");

        // R7: beyond the register file
        sel_idx("R7", 20); wr_reg("R7", 'h99); rd_reg("R7");
        sel_idx("R7", 31); wr_reg("R7", 'h00); rd_reg("R7");
        sel_idx("R7", 18); rd_reg("R7");

        // R9: vertical border flag
        cyc("R9", mk_addr(2), 0, 1, 0, 0, 0, 1, 0);
        rd_stat("R9");
        cyc("R9", mk_addr(2), 0, 1, 0, 0, 0, 0, 1);
        rd_stat("R9");
        cyc("R9", mk_addr(2), 0, 1, 0, 0, 0, 1, 1);
        rd_stat("R9");

        // R11: no read strobe
        sel_idx("R11", 14);
        cyc("R11", mk_addr(3), 0, 0, 0);

        // random mix of everything
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] a;
            a = mk_addr(int'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) a[14] = 1'b1;
            cyc("R2", a, int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
                int'($urandom_range(0, 16383)), bit'($urandom_range(0, 1)),
                $urandom_range(0, 15) == 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule